// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Per-Source Fast/Normal Routing

This block gathers 32 level-sensitive interrupt request lines into two processor interrupt outputs: a normal request and a fast request. Each source has its own enable bit and its own routing bit, which picks the output it drives. Sources are not latched. A source is pending for as long as its input line is high. Software quiets a source by clearing its enable bit, so acknowledging a request is the same as masking it.

A small register port with 32-bit reads and writes gives software three kinds of pending status (raw, normal-routed and fast-routed) and read/write access to the enable, routing and control registers. The block also drives a wake request for a processor that is idle and waiting for an interrupt. Control bit 0 decides whether every raw request may wake the processor, or only enabled ones. A registered index with a valid flag names the lowest-numbered enabled, normal-routed pending source, which is the one to service first. Sources 0 to 11 are expected to come from pin logic, and sources 12 to 31 from on-chip peripherals. The block treats all 32 alike.

Top module: `irq_router`

## Requirements
- R1: After reset, the enable, routing and control registers read as zero, and irq_o, fiq_o, irq_idx_vld and irq_idx are low.
- R2: Offset 0x04 (enable), offset 0x08 (routing) and offset 0x0C (control) read back what was last written to them. Control keeps only bit 0; its bits 31:1 read as zero.
- R3: A read of offset 0x00 returns src & en & ~route. A read of offset 0x10 returns src & en & route. A read of offset 0x20 returns src. Here src is the request input sampled at the read strobe.
- R4: irq_o is high in the cycle after a clock edge at which any bit of src & en & ~route was set, and low otherwise.
- R5: fiq_o is high in the cycle after a clock edge at which any bit of src & en & route was set, and low otherwise.
- R6: irq_idx_vld follows irq_o. When it is high, irq_idx holds the lowest set bit position of src & en & ~route from the previous edge, in the range 0 to 31.
- R7: With control bit 0 at 0, wake_o is high one cycle after any src bit is set, whatever the enable bits. With control bit 0 at 1, only src & en counts.
- R8: Writes to offsets 0x00, 0x10, 0x20 or any unmapped offset change no register. Reads of unmapped offsets return zero.
- R9: There is no latch. Pending status and the outputs drop one cycle after a source line falls or its enable bit is cleared.
- R10: Read data appears on reg_rdata one clock after the read strobe. A write takes effect at the clock edge where reg_wr is sampled, and the outputs reflect it one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Level-sensitive request lines |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle-wake request |
| irq_idx | output | 5 | Lowest pending normal-routed source |
| irq_idx_vld | output | 1 | irq_idx is meaningful |

## Verification
The hardest case to reach is a mix of enabled sources spread across both routes, where the lowest set raw bit is fast-routed or disabled, so the index must skip it and land on a higher normal-routed bit. Random enable and routing patterns at about half density, with dense request vectors, produce many such cases. Directed steps add the extreme indices 0 and 31, a case where everything is fast-routed, and the wake behaviour when only disabled sources are raised under each control setting.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int unsigned SRC_N  = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned IDX_W  = $clog2(SRC_N);

    localparam logic [ADDR_W-1:0] OFS_IRQ_PEND = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ENABLE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ROUTE    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_FIQ_PEND = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_RAW      = 8'h20;

    typedef struct packed {
        logic [SRC_N-1:0] en;
        logic [SRC_N-1:0] route;
        logic             wake_sel;
    } cfg_t;

    typedef struct packed {
        logic              irq;
        logic              fiq;
        logic              wake;
        logic [IDX_W-1:0]  idx;
        logic              vld;
        logic [DATA_W-1:0] rdata;
    } out_t;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_router_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (addr)
                OFS_ENABLE: cfg_d.en       = wdata[SRC_N-1:0];
                OFS_ROUTE:  cfg_d.route    = wdata[SRC_N-1:0];
                OFS_CTRL:   cfg_d.wake_sel = wdata[0];
                default:    cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_router_pkg::*;
#(
    parameter int unsigned N = SRC_N
) (
    input  logic [N-1:0] raw,
    input  logic [N-1:0] en,
    input  logic [N-1:0] route,
    input  logic         wake_sel,
    output logic [N-1:0] irq_pend,
    output logic [N-1:0] fiq_pend,
    output logic         wake_req
);

    logic [N-1:0] live;

    for (genvar g = 0; g < N; g++) begin : g_src
        assign live[g]     = raw[g] & en[g];
        assign irq_pend[g] = live[g] & ~route[g];
        assign fiq_pend[g] = live[g] &  route[g];
    end

    always_comb begin
        if (wake_sel) wake_req = |live;
        else          wake_req = |raw;
    end

endmodule

// File: rtl/irq_lowest.sv
module irq_lowest
    import irq_router_pkg::*;
#(
    parameter int unsigned N  = SRC_N,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          vld
);

    always_comb begin
        idx = '0;
        vld = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                vld = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  irq_src,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              wake_o,
    output logic [IDX_W-1:0]  irq_idx,
    output logic              irq_idx_vld
);

    cfg_t             cfg;
    logic [SRC_N-1:0] irq_pend, fiq_pend;
    logic             wake_req;
    logic [IDX_W-1:0] low_idx;
    logic             low_vld;
    out_t             out_d, out_q;

    irq_cfg_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr),
        .addr(reg_addr), .wdata(reg_wdata), .cfg(cfg)
    );

    irq_route #(.N(SRC_N)) u_route (
        .raw(irq_src), .en(cfg.en), .route(cfg.route), .wake_sel(cfg.wake_sel),
        .irq_pend(irq_pend), .fiq_pend(fiq_pend), .wake_req(wake_req)
    );

    irq_lowest #(.N(SRC_N), .IW(IDX_W)) u_low (
        .vec(irq_pend), .idx(low_idx), .vld(low_vld)
    );

    always_comb begin
        out_d      = out_q;
        out_d.irq  = |irq_pend;
        out_d.fiq  = |fiq_pend;
        out_d.wake = wake_req;
        out_d.idx  = low_idx;
        out_d.vld  = low_vld;
        if (reg_rd) begin
            unique case (reg_addr)
                OFS_IRQ_PEND: out_d.rdata = DATA_W'(irq_pend);
                OFS_ENABLE:   out_d.rdata = DATA_W'(cfg.en);
                OFS_ROUTE:    out_d.rdata = DATA_W'(cfg.route);
                OFS_CTRL:     out_d.rdata = DATA_W'(cfg.wake_sel);
                OFS_FIQ_PEND: out_d.rdata = DATA_W'(fiq_pend);
                OFS_RAW:      out_d.rdata = DATA_W'(irq_src);
                default:      out_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign reg_rdata   = out_q.rdata;
    assign irq_o       = out_q.irq;
    assign fiq_o       = out_q.fiq;
    assign wake_o      = out_q.wake;
    assign irq_idx     = out_q.idx;
    assign irq_idx_vld = out_q.vld;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_N-1:0]  irq_src,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_o,
    input logic              fiq_o,
    input logic              wake_o,
    input logic [IDX_W-1:0]  irq_idx,
    input logic              irq_idx_vld,
    input logic [SRC_N-1:0]  en,
    input logic [SRC_N-1:0]  route,
    input logic              wake_sel
);

    logic             seen;
    logic [SRC_N-1:0] ipend, fpend, below;
    logic             unmapped, wake_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assign ipend    = irq_src & en & ~route;
    assign fpend    = irq_src & en & route;
    assign below    = (SRC_N'(1) << irq_idx) - SRC_N'(1);
    assign wake_exp = wake_sel ? |(irq_src & en) : |irq_src;
    assign unmapped = !(reg_addr inside {OFS_IRQ_PEND, OFS_ENABLE, OFS_ROUTE,
                                         OFS_CTRL, OFS_FIQ_PEND, OFS_RAW});

    // R4
    irq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (irq_o == |$past(ipend)));

    // R5
    fiq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (fiq_o == |$past(fpend)));

    // R6
    idx_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && irq_idx_vld) |-> ((($past(ipend) >> irq_idx) & SRC_N'(1)) == SRC_N'(1)));

    // R6
    idx_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && irq_idx_vld) |-> (($past(ipend) & below) == '0));

    // R6
    idx_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (irq_idx_vld == irq_o));

    // R7
    wake_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (wake_o == $past(wake_exp)));

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(reg_rd) && $past(unmapped)) |-> (reg_rdata == '0));

endmodule

bind irq_router irq_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o),
    .wake_o(wake_o), .irq_idx(irq_idx), .irq_idx_vld(irq_idx_vld),
    .en(cfg.en), .route(cfg.route), .wake_sel(cfg.wake_sel)
);

// File: tb/irq_router_test.sv
module irq_router_test;
    import irq_router_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o, fiq_o, wake_o, irq_idx_vld;
    logic [4:0]  irq_idx;

    int n_run = 0, n_fail = 0;
    logic [31:0] m_en = '0, m_rt = '0;
    logic        m_ctl = 1'b0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    irq_router uut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o),
        .irq_idx(irq_idx), .irq_idx_vld(irq_idx_vld)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [31:0] s);
        case (a)
            8'h00:   return s & m_en & ~m_rt;
            8'h04:   return m_en;
            8'h08:   return m_rt;
            8'h0C:   return {31'd0, m_ctl};
            8'h10:   return s & m_en & m_rt;
            8'h20:   return s;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [5:0] exp_low(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return {1'b1, 5'(i)};
        return 6'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            8'h04: m_en = d;
            8'h08: m_rt = d;
            8'h0C: m_ctl = d[0];
            default: ;
        endcase
    endtask

    task automatic rd_check(input string req, input logic [7:0] a);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        check(req, reg_rdata, exp_read(a, irq_src));
    endtask

    task automatic drive_and_check(input logic [31:0] s);
        logic [31:0] ip, fp;
        logic [5:0]  lo;
        logic        wk;
        irq_src = s;
        @(negedge clk);
        ip = s & m_en & ~m_rt;
        fp = s & m_en & m_rt;
        lo = exp_low(ip);
        wk = m_ctl ? |(s & m_en) : |s;
        check("R4 irq_o", 32'(irq_o), 32'(|ip));
        check("R5 fiq_o", 32'(fiq_o), 32'(|fp));
        check("R6 vld", 32'(irq_idx_vld), 32'(lo[5]));
        if (lo[5]) check("R6 idx", 32'(irq_idx), 32'(lo[4:0]));
        check("R7 wake", 32'(wake_o), 32'(wk));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq_o", 32'(irq_o), 0);
        check("R1 fiq_o", 32'(fiq_o), 0);
        check("R1 vld", 32'(irq_idx_vld), 0);
        check("R1 idx", 32'(irq_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_check("R1 en", 8'h04);
        rd_check("R1 route", 8'h08);
        rd_check("R1 ctrl", 8'h0C);

        // R2 readback, control only bit 0
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_check("R2 ctrl", 8'h0C);
        wr(8'h04, 32'hA5A5_0F0F);
        rd_check("R2 en", 8'h04);
        wr(8'h08, 32'h0000_FFFF);
        rd_check("R2 route", 8'h08);

        // R8 writes to status/unmapped offsets ignored
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h10, 32'h1234_5678);
        wr(8'h20, 32'h0); wr(8'h14, 32'h0); wr(8'h05, 32'h0);
        rd_check("R8 en kept", 8'h04);
        rd_check("R8 route kept", 8'h08);
        rd_check("R8 ctrl kept", 8'h0C);
        irq_src = 32'hFFFF_FFFF;
        rd_check("R8 unmapped 0x14", 8'h14);
        rd_check("R8 unmapped 0xFC", 8'hFC);

        // R6 extremes
        wr(8'h04, 32'hFFFF_FFFF); wr(8'h08, 32'h0);
        drive_and_check(32'h8000_0000);
        drive_and_check(32'h0000_0001);
        drive_and_check(32'hFFFF_FFFF);
        // all fast-routed: no index
        wr(8'h08, 32'hFFFF_FFFF);
        drive_and_check(32'hFFFF_FFFF);
        // lowest raw bit fast-routed, index must skip it
        wr(8'h08, 32'h0000_0007);
        drive_and_check(32'h0001_0005);

        // R7 wake with only disabled sources
        wr(8'h04, 32'h0000_00FF);
        wr(8'h0C, 32'h0);
        drive_and_check(32'hFF00_0000);
        wr(8'h0C, 32'h1);
        drive_and_check(32'hFF00_0000);
        drive_and_check(32'h0000_0100);

        // R9 level, no latch: drop line, then mask
        wr(8'h08, 32'h0);
        drive_and_check(32'h0000_0010);
        drive_and_check(32'h0000_0000);
        drive_and_check(32'h0000_0010);
        wr(8'h04, 32'h0);
        drive_and_check(32'h0000_0010);

        // R3 status reads and R10 timing under random patterns
        for (int it = 0; it < 400; it++) begin
            logic [7:0] a;
            logic [2:0] pick;
            pick = 3'($urandom_range(0, 7));
            case (pick)
                3'd0, 3'd1: a = 8'h04;
                3'd2, 3'd3: a = 8'h08;
                3'd4:       a = 8'h0C;
                3'd5:       a = 8'h10;
                3'd6:       a = 8'h20;
                default:    a = 8'($urandom_range(0, 255));
            endcase
            wr(a, $urandom() & ($urandom_range(0, 1) ? $urandom() : 32'hFFFF_FFFF));
            drive_and_check($urandom() | $urandom());
            case (3'($urandom_range(0, 6)))
                3'd0: rd_check("R3 irq pend", 8'h00);
                3'd1: rd_check("R3 fiq pend", 8'h10);
                3'd2: rd_check("R3 raw", 8'h20);
                3'd3: rd_check("R10 en", 8'h04);
                3'd4: rd_check("R10 route", 8'h08);
                3'd5: rd_check("R2 ctrl", 8'h0C);
                default: rd_check("R8 rand", 8'($urandom_range(0, 255)));
            endcase
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule